// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Detector

This block compares the timing of a reference square wave with the feedback square wave of an oscillator and produces a three-state correction signal for a loop filter. A fast system clock samples both inputs, and only their rising edges matter. When the reference edge arrives first, the block drives its correction output high to ask for a higher oscillator frequency. When the feedback edge arrives first, it drives the output low. Once the lagging edge arrives, it releases the output to high impedance, so the filter holds its voltage. Over repeated cycles this pushes the loop towards zero phase difference between the two sets of rising edges.

The three-state output is modelled by two bits, a drive enable and a drive value, so it can be checked without analog parts. A separate phase-pulse output is high whenever the correction output is released, and it serves as a raw lock indication. A second rising edge on the same input before the other input has produced one keeps the present drive direction. This makes the block a frequency detector as well as a phase detector, with no wrap-around.

Top module: `pfd_top`

## Requirements
- R1: Falling edges and steady levels on either input never change the outputs. The duty cycle of either input has no effect.
- R2: From the released state, a reference rising edge alone puts the output in drive-high: drv_en=1 and drv_val=1.
- R3: In drive-high, a feedback rising edge releases the output: drv_en=0 and drv_val=0.
- R4: From the released state, a feedback rising edge alone puts the output in drive-low: drv_en=1 and drv_val=0. A reference rising edge in drive-low releases the output.
- R5: Rising edges on both inputs in the same system-clock cycle leave a released output released.
- R6: A further rising edge on the input that started the present drive keeps the drive direction unchanged.
- R7: lock_pulse is the inverse of drv_en on every cycle.
- R8: A synchronous active-high rst releases the output, with lock_pulse=1. It also clears the synchronizer stages, so a level still present at release is seen as a fresh rising edge.
- R9: An input change made before clock edge k shows at the outputs after clock edge k+2 and not earlier. This delay comes from a two-stage synchronizer followed by a registered edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system sampling clock |
| rst | input | 1 | synchronous active-high reset |
| ref_in | input | 1 | asynchronous reference square wave |
| fb_in | input | 1 | asynchronous oscillator feedback square wave |
| drv_en | output | 1 | correction output is actively driven |
| drv_val | output | 1 | level driven when drv_en is 1 (1 = raise frequency) |
| lock_pulse | output | 1 | high while the correction output is released |

## Verification
The hardest cases to reach are a repeated edge on one input while a drive is already under way, and an exact coincidence of both edges in one sampling cycle. The stimulus reaches both by changing the input levels only on falling clock edges and holding each pattern for three clock periods. That way every transition enters the synchronizers in a known cycle: raising both inputs in the same step gives coincident edges, and a fall followed by a rise on one input gives a repeated edge. A directed test counts edges to confirm the exact three-edge latency.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ST_REL  = 2'b00,
    ST_UP   = 2'b01,
    ST_DOWN = 2'b10
  } pfd_state_t;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic drv_en,
  output logic drv_val,
  output logic lock_pulse
);
  pfd_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_REL: begin
        if (ref_rise && !fb_rise)      st_d = ST_UP;
        else if (fb_rise && !ref_rise) st_d = ST_DOWN;
      end
      ST_UP:   if (fb_rise)  st_d = ST_REL;
      ST_DOWN: if (ref_rise) st_d = ST_REL;
      default: st_d = ST_REL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_REL;
      drv_en     <= 1'b0;
      drv_val    <= 1'b0;
      lock_pulse <= 1'b1;
    end else begin
      st_q       <= st_d;
      drv_en     <= (st_d != ST_REL);
      drv_val    <= (st_d == ST_UP);
      lock_pulse <= (st_d == ST_REL);
    end
  end
endmodule

// File: rtl/pfd_top.sv
module pfd_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic drv_en,
  output logic drv_val,
  output logic lock_pulse
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw, syn, rise;
  assign raw = {fb_in, ref_in};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(raw[i]), .q(syn[i])
    );
    pfd_edge u_edge (
      .clk(clk), .rst(rst), .lvl(syn[i]), .rise(rise[i])
    );
  end

  pfd_core u_core (
    .clk(clk), .rst(rst),
    .ref_rise(rise[0]), .fb_rise(rise[1]),
    .drv_en(drv_en), .drv_val(drv_val), .lock_pulse(lock_pulse)
  );
endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
  input logic clk,
  input logic rst,
  input logic ref_in,
  input logic fb_in,
  input logic drv_en,
  input logic drv_val,
  input logic lock_pulse
);
  // R7
  a_r7_lock_inverse: assert property (@(posedge clk) disable iff (rst)
    lock_pulse == !drv_en);

  // R8
  a_r8_reset_releases: assert property (@(posedge clk)
    $past(rst) |-> (!drv_en && lock_pulse));

  // R2
  a_r2_up_needs_ref: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en && drv_val) |-> $past(ref_in, 2));

  // R4
  a_r4_down_needs_fb: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en && !drv_val) |-> $past(fb_in, 2));

  // R3
  a_r3_release_needs_edge: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv_en) && !$past(rst)) |-> ($past(fb_in, 2) || $past(ref_in, 2)));

  // R2
  a_r2_val_only_when_driven: assert property (@(posedge clk) disable iff (rst)
    drv_val |-> drv_en);
endmodule

bind pfd_top pfd_chk u_chk (
  .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
  .drv_en(drv_en), .drv_val(drv_val), .lock_pulse(lock_pulse)
);

// File: tb/tb_pfd_top.sv
module tb_pfd_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic drv_en, drv_val, lock_pulse;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pfd_top dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .drv_en(drv_en), .drv_val(drv_val), .lock_pulse(lock_pulse)
  );

  // {ref, fb, exp_en, exp_val}; exp lock = ~exp_en
  localparam int NV = 18;
  localparam logic [3:0] VEC [NV] = '{
    4'b1011, // R2 ref leads
    4'b1100, // R3 fb arrives
    4'b0000, // R1 falling edges
    4'b0110, // R4 fb leads
    4'b1100, // R4 ref releases
    4'b0000,
    4'b1100, // R5 coincident
    4'b0000,
    4'b1011, // R2
    4'b0011, // R1 ref falls
    4'b1011, // R6 second ref edge
    4'b1100, // R3
    4'b0000,
    4'b0110, // R4
    4'b0010, // R1 fb falls
    4'b0110, // R6 second fb edge
    4'b1100, // R4 release
    4'b0000
  };

  task automatic chk(input string req, input logic en, input logic val);
    checks++;
    if (drv_en !== en || drv_val !== val || lock_pulse !== !en) begin
      errors++;
      $display("FAIL %s: en/val/lock=%b%b%b expected %b%b%b",
               req, drv_en, drv_val, lock_pulse, en, val, !en);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R8 reset", 1'b0, 1'b0);
    rst = 1'b0;
    step(3);
    chk("R8 idle after reset", 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      ref_in = VEC[v][3];
      fb_in  = VEC[v][2];
      step(3);
      chk($sformatf("R1-vector %0d", v), VEC[v][1], VEC[v][0]);
    end

    // R9 latency: change at negedge, two edges no change, third edge change
    ref_in = 1'b1;
    step(2);
    chk("R9 not yet", 1'b0, 1'b0);
    step(1);
    chk("R9 after three edges", 1'b1, 1'b1);

    // R8 reset while driving
    rst = 1'b1;
    step(1);
    chk("R8 reset during drive", 1'b0, 1'b0);
    ref_in = 1'b0;
    step(3);
    rst = 1'b0;
    step(3);
    chk("R8 stays released", 1'b0, 1'b0);

    // R8 level held through reset is a fresh edge
    fb_in = 1'b1;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(3);
    chk("R8 held level seen as edge", 1'b1, 1'b0);
    ref_in = 1'b1;
    step(3);
    chk("R4 release after reset", 1'b0, 1'b0);

    // repeated lag over several cycles
    ref_in = 1'b0; fb_in = 1'b0;
    step(3);
    for (int c = 0; c < 3; c++) begin
      ref_in = 1'b1;
      step(3);
      chk("R2 repeated lag", 1'b1, 1'b1);
      fb_in = 1'b1;
      step(3);
      chk("R3 repeated lag", 1'b0, 1'b0);
      ref_in = 1'b0; fb_in = 1'b0;
      step(3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule